// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This unit sits between a fetch buffer of decoded instructions and two execution pipes of different kinds. The first pipe takes integer-side work. The second takes floating-point computation. On every clock it looks at the two oldest buffered instructions, the older in slot 0 and the younger in slot 1. It decides whether to dispatch none, the older alone, or both together. It then tells the buffer how many entries to drop from its head.

Dual issue happens only when one instruction of the pair belongs on the integer side and the other is a floating-point computation. The younger instruction must also not read a register that the older one writes. Program order is kept, because the younger slot never goes out without the older one.

Register identifiers form one shared namespace, so the integer and floating-point files are told apart by the identifier itself. All outputs are registered: a decision on the inputs seen at one rising edge appears on the outputs just after that edge.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both issue strobes and `consumed` are 0.
- R2: The class code selects the pipe. Code 1 (integer ALU, branch, integer load/store) goes to the integer pipe. Code 2 (floating-point load/store) also goes to the integer pipe. Code 3 (floating-point add, subtract, multiply-add, convert) goes to the floating-point pipe.
- R3: An older integer-side instruction paired with a younger code-3 instruction, or an older code-3 instruction paired with a younger integer-side instruction, issues both in the same cycle with `consumed` = 2.
- R4: When both slots map to the same pipe, only the older slot issues and `consumed` = 1.
- R5: When `s0_wr` is 1 and `s0_dst` equals `s1_src_a` or `s1_src_b`, only the older slot issues. When `s0_wr` is 0, no dependence is detected.
- R6: When `s0_valid` is 0, nothing issues and `consumed` = 0, whatever slot 1 holds.
- R7: When `stall` is 1, nothing issues and `consumed` = 0.
- R8: A class code of 0 or 4 to 7 is unknown. It issues on the integer pipe and never pairs, in either slot.
- R9: Each issue strobe carries the tag of the slot that was selected for that pipe.
- R10: `consumed` always equals the number of issue strobes that are high. Outputs show the decision for the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Blocks all issue this cycle |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_cls | input | 3 | Older slot class code |
| s0_dst | input | REG_W | Older slot destination register |
| s0_wr | input | 1 | Older slot writes `s0_dst` |
| s0_tag | input | TAG_W | Older slot instruction tag |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_cls | input | 3 | Younger slot class code |
| s1_src_a | input | REG_W | Younger slot first source register |
| s1_src_b | input | REG_W | Younger slot second source register |
| s1_tag | input | TAG_W | Younger slot instruction tag |
| int_issue | output | 1 | Integer pipe issue strobe |
| int_tag | output | TAG_W | Tag sent to the integer pipe |
| fp_issue | output | 1 | Floating-point pipe issue strobe |
| fp_tag | output | TAG_W | Tag sent to the floating-point pipe |
| consumed | output | 2 | Entries to drop from the fetch buffer (0, 1 or 2) |

## Verification
A wrong steering or pairing decision shows up one cycle after the inputs are presented, in one of three ways. A strobe can rise on the wrong pipe. `consumed` can disagree with the number of strobes. A tag can belong to the wrong slot. A missed dependence makes `consumed` read 2 where 1 is due. The fetch buffer would then drop a younger instruction that never issued, which is a loss that nothing downstream could repair. Because the unit holds no state beyond its output register, every fault is visible on the very next cycle and never later.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int CLS_W = 3;

  localparam logic [CLS_W-1:0] CLS_INT   = 3'd1;
  localparam logic [CLS_W-1:0] CLS_FPMEM = 3'd2;
  localparam logic [CLS_W-1:0] CLS_FPC   = 3'd3;

  typedef struct packed {
    logic to_fp;   // routed to floating-point compute pipe
    logic solo;    // may not take part in a pair
  } steer_t;
endpackage

// File: rtl/pair_slot_class.sv
module pair_slot_class
  import pair_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output steer_t           steer
);
  always_comb begin
    steer = '{to_fp: 1'b0, solo: 1'b0};
    unique case (cls)
      CLS_INT, CLS_FPMEM: steer.to_fp = 1'b0;
      CLS_FPC:            steer.to_fp = 1'b1;
      default:            steer.solo  = 1'b1;
    endcase
  end
endmodule

// File: rtl/pair_raw_check.sv
module pair_raw_check #(
  parameter int REG_W = 6
) (
  input  logic             older_wr,
  input  logic [REG_W-1:0] older_dst,
  input  logic [REG_W-1:0] young_src_a,
  input  logic [REG_W-1:0] young_src_b,
  output logic             hit
);
  logic [1:0] match;
  always_comb begin
    match[0] = (young_src_a == older_dst);
    match[1] = (young_src_b == older_dst);
    hit      = older_wr && (|match);
  end
endmodule

// File: rtl/pair_select.sv
module pair_select
  import pair_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             stall,
  input  logic             v0,
  input  logic             v1,
  input  steer_t           st0,
  input  steer_t           st1,
  input  logic             raw_hit,
  input  logic [TAG_W-1:0] tag0,
  input  logic [TAG_W-1:0] tag1,
  output logic             int_v,
  output logic [TAG_W-1:0] int_t,
  output logic             fp_v,
  output logic [TAG_W-1:0] fp_t,
  output logic [1:0]       cnt
);
  logic go0, pair;

  always_comb begin
    go0  = v0 && !stall;
    pair = go0 && v1 && !st0.solo && !st1.solo &&
           (st0.to_fp != st1.to_fp) && !raw_hit;

    int_v = 1'b0;
    int_t = '0;
    fp_v  = 1'b0;
    fp_t  = '0;

    if (go0 && !st0.to_fp) begin
      int_v = 1'b1;
      int_t = tag0;
    end else if (pair && !st1.to_fp) begin
      int_v = 1'b1;
      int_t = tag1;
    end

    if (go0 && st0.to_fp) begin
      fp_v = 1'b1;
      fp_t = tag0;
    end else if (pair && st1.to_fp) begin
      fp_v = 1'b1;
      fp_t = tag1;
    end

    cnt = !go0 ? 2'd0 : (pair ? 2'd2 : 2'd1);
  end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pair_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             s0_valid,
  input  logic [2:0]       s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s0_wr,
  input  logic [TAG_W-1:0] s0_tag,
  input  logic             s1_valid,
  input  logic [2:0]       s1_cls,
  input  logic [REG_W-1:0] s1_src_a,
  input  logic [REG_W-1:0] s1_src_b,
  input  logic [TAG_W-1:0] s1_tag,
  output logic             int_issue,
  output logic [TAG_W-1:0] int_tag,
  output logic             fp_issue,
  output logic [TAG_W-1:0] fp_tag,
  output logic [1:0]       consumed
);
  localparam int SLOTS = 2;

  logic [CLS_W-1:0] cls_arr [SLOTS];
  steer_t           steer   [SLOTS];
  logic             raw_hit;
  logic             n_int_v, n_fp_v;
  logic [TAG_W-1:0] n_int_t, n_fp_t;
  logic [1:0]       n_cnt;

  assign cls_arr[0] = s0_cls;
  assign cls_arr[1] = s1_cls;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    pair_slot_class u_cls (
      .cls   (cls_arr[g]),
      .steer (steer[g])
    );
  end

  pair_raw_check #(.REG_W(REG_W)) u_raw (
    .older_wr    (s0_wr),
    .older_dst   (s0_dst),
    .young_src_a (s1_src_a),
    .young_src_b (s1_src_b),
    .hit         (raw_hit)
  );

  pair_select #(.TAG_W(TAG_W)) u_sel (
    .stall   (stall),
    .v0      (s0_valid),
    .v1      (s1_valid),
    .st0     (steer[0]),
    .st1     (steer[1]),
    .raw_hit (raw_hit),
    .tag0    (s0_tag),
    .tag1    (s1_tag),
    .int_v   (n_int_v),
    .int_t   (n_int_t),
    .fp_v    (n_fp_v),
    .fp_t    (n_fp_t),
    .cnt     (n_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_issue <= 1'b0;
      int_tag   <= '0;
      fp_issue  <= 1'b0;
      fp_tag    <= '0;
      consumed  <= 2'd0;
    end else begin
      int_issue <= n_int_v;
      int_tag   <= n_int_t;
      fp_issue  <= n_fp_v;
      fp_tag    <= n_fp_t;
      consumed  <= n_cnt;
    end
  end
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk #(
  parameter int REG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             stall,
  input logic             s0_valid,
  input logic [2:0]       s0_cls,
  input logic [REG_W-1:0] s0_dst,
  input logic             s0_wr,
  input logic             s1_valid,
  input logic [2:0]       s1_cls,
  input logic [REG_W-1:0] s1_src_a,
  input logic             int_issue,
  input logic             fp_issue,
  input logic [1:0]       consumed
);
  // R10: count agrees with strobes
  a_r10_count_matches: assert property (@(posedge clk) disable iff (rst)
    $countones({int_issue, fp_issue}) == consumed);

  // R6: no issue without the older slot
  a_r6_older_required: assert property (@(posedge clk) disable iff (rst)
    !s0_valid |=> (consumed == 2'd0) && !int_issue && !fp_issue);

  // R7: stall silences the unit
  a_r7_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    stall |=> !int_issue && !fp_issue && (consumed == 2'd0));

  // R4: two floating-point computations never pair
  a_r4_same_side_single: assert property (@(posedge clk) disable iff (rst)
    (s0_valid && s1_valid && !stall && s0_cls == 3'd3 && s1_cls == 3'd3)
    |=> fp_issue && !int_issue && (consumed == 2'd1));

  // R5: dependence on first source blocks pairing
  a_r5_raw_single: assert property (@(posedge clk) disable iff (rst)
    (s0_valid && s1_valid && !stall && s0_wr && s0_dst == s1_src_a)
    |=> consumed != 2'd2);

  // R8: unknown older class goes alone to the integer pipe
  a_r8_unknown_alone: assert property (@(posedge clk) disable iff (rst)
    (s0_valid && !stall && (s0_cls == 3'd0 || s0_cls[2]))
    |=> int_issue && !fp_issue && (consumed == 2'd1));
endmodule

bind dual_issue_pair dual_issue_pair_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .s0_valid  (s0_valid),
  .s0_cls    (s0_cls),
  .s0_dst    (s0_dst),
  .s0_wr     (s0_wr),
  .s1_valid  (s1_valid),
  .s1_cls    (s1_cls),
  .s1_src_a  (s1_src_a),
  .int_issue (int_issue),
  .fp_issue  (fp_issue),
  .consumed  (consumed)
);

// File: tb/tb_dual_issue_pair.sv
`timescale 1ns/1ps
module tb_dual_issue_pair;
  localparam int REG_W = 6;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst, stall;
  logic s0_valid, s0_wr, s1_valid;
  logic [2:0] s0_cls, s1_cls;
  logic [REG_W-1:0] s0_dst, s1_src_a, s1_src_b;
  logic [TAG_W-1:0] s0_tag, s1_tag;
  logic int_issue, fp_issue;
  logic [TAG_W-1:0] int_tag, fp_tag;
  logic [1:0] consumed;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dual_issue_pair #(.REG_W(REG_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst), .stall(stall),
    .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_wr(s0_wr), .s0_tag(s0_tag),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_src_a(s1_src_a), .s1_src_b(s1_src_b),
    .s1_tag(s1_tag),
    .int_issue(int_issue), .int_tag(int_tag), .fp_issue(fp_issue), .fp_tag(fp_tag),
    .consumed(consumed)
  );

  task automatic set_s0(input logic v, input logic [2:0] c, input logic [REG_W-1:0] d,
                        input logic w, input logic [TAG_W-1:0] t);
    s0_valid = v; s0_cls = c; s0_dst = d; s0_wr = w; s0_tag = t;
  endtask

  task automatic set_s1(input logic v, input logic [2:0] c, input logic [REG_W-1:0] a,
                        input logic [REG_W-1:0] b, input logic [TAG_W-1:0] t);
    s1_valid = v; s1_cls = c; s1_src_a = a; s1_src_b = b; s1_tag = t;
  endtask

  // compare current outputs; tags only when the strobe is expected high
  task automatic cmp(input string req, input logic ei, input logic [TAG_W-1:0] eit,
                     input logic ef, input logic [TAG_W-1:0] eft, input logic [1:0] ec);
    n_chk++;
    if (int_issue !== ei || fp_issue !== ef || consumed !== ec ||
        (ei && int_tag !== eit) || (ef && fp_tag !== eft)) begin
      n_bad++;
      $display("FAIL %s: got int=%0b/%h fp=%0b/%h cnt=%0d exp int=%0b/%h fp=%0b/%h cnt=%0d",
               req, int_issue, int_tag, fp_issue, fp_tag, consumed,
               ei, eit, ef, eft, ec);
    end
  endtask

  // inputs were set after a falling edge; result registered at the next rising edge
  task automatic step_cmp(input string req, input logic ei, input logic [TAG_W-1:0] eit,
                          input logic ef, input logic [TAG_W-1:0] eft, input logic [1:0] ec);
    @(posedge clk); #1;
    cmp(req, ei, eit, ef, eft, ec);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; stall = 1'b0;
    set_s0(1, 3'd1, 6'd1, 1, 8'hA0);
    set_s1(1, 3'd3, 6'd2, 6'd3, 8'hA1);
    repeat (2) @(posedge clk);
    #1 cmp("R1 during reset", 0, 0, 0, 0, 2'd0);
    @(negedge clk); rst = 1'b0;
    set_s0(0, 3'd1, 6'd0, 0, 8'h00);
    set_s1(0, 3'd1, 6'd0, 6'd0, 8'h00);
    step_cmp("R1 first cycle after reset", 0, 0, 0, 0, 2'd0);
  endtask

  task automatic t_steer;
    set_s0(1, 3'd1, 6'd4, 1, 8'h11); set_s1(0, 3'd3, 6'd0, 6'd0, 8'h12);
    step_cmp("R2 alu to int pipe", 1, 8'h11, 0, 0, 2'd1);
    set_s0(1, 3'd2, 6'd40, 1, 8'h21);
    step_cmp("R2 fp load/store to int pipe", 1, 8'h21, 0, 0, 2'd1);
    set_s0(1, 3'd3, 6'd41, 1, 8'h31);
    step_cmp("R2 R9 fp compute to fp pipe", 0, 0, 1, 8'h31, 2'd1);
  endtask

  task automatic t_pair;
    set_s0(1, 3'd1, 6'd5, 1, 8'h41); set_s1(1, 3'd3, 6'd33, 6'd34, 8'h42);
    step_cmp("R3 R9 int older + fpc younger", 1, 8'h41, 1, 8'h42, 2'd2);
    set_s0(1, 3'd3, 6'd35, 1, 8'h51); set_s1(1, 3'd2, 6'd7, 6'd8, 8'h52);
    step_cmp("R3 R9 fpc older + fp mem younger", 1, 8'h52, 1, 8'h51, 2'd2);
  endtask

  task automatic t_same;
    set_s0(1, 3'd1, 6'd5, 1, 8'h61); set_s1(1, 3'd1, 6'd9, 6'd10, 8'h62);
    step_cmp("R4 int + int", 1, 8'h61, 0, 0, 2'd1);
    set_s0(1, 3'd3, 6'd36, 1, 8'h63); set_s1(1, 3'd3, 6'd37, 6'd38, 8'h64);
    step_cmp("R4 fpc + fpc", 0, 0, 1, 8'h63, 2'd1);
    set_s0(1, 3'd2, 6'd39, 1, 8'h65); set_s1(1, 3'd1, 6'd11, 6'd12, 8'h66);
    step_cmp("R4 fp mem + int", 1, 8'h65, 0, 0, 2'd1);
  endtask

  task automatic t_raw;
    set_s0(1, 3'd2, 6'd42, 1, 8'h71); set_s1(1, 3'd3, 6'd43, 6'd42, 8'h72);
    step_cmp("R5 dependence on src_b", 1, 8'h71, 0, 0, 2'd1);
    set_s1(1, 3'd3, 6'd42, 6'd44, 8'h73);
    step_cmp("R5 dependence on src_a", 1, 8'h71, 0, 0, 2'd1);
    s0_wr = 1'b0;
    step_cmp("R5 no write no dependence", 1, 8'h71, 1, 8'h73, 2'd2);
    set_s0(1, 3'd2, 6'd45, 1, 8'h74); set_s1(1, 3'd3, 6'd46, 6'd47, 8'h75);
    step_cmp("R5 different registers pair", 1, 8'h74, 1, 8'h75, 2'd2);
  endtask

  task automatic t_older_invalid;
    set_s0(0, 3'd1, 6'd1, 1, 8'h81); set_s1(1, 3'd3, 6'd2, 6'd3, 8'h82);
    step_cmp("R6 younger alone never issues", 0, 0, 0, 0, 2'd0);
  endtask

  task automatic t_stall;
    set_s0(1, 3'd1, 6'd1, 1, 8'h91); set_s1(1, 3'd3, 6'd50, 6'd51, 8'h92);
    stall = 1'b1;
    step_cmp("R7 stall blocks pair", 0, 0, 0, 0, 2'd0);
    stall = 1'b0;
    step_cmp("R7 release issues pair", 1, 8'h91, 1, 8'h92, 2'd2);
  endtask

  task automatic t_unknown;
    set_s0(1, 3'd5, 6'd1, 1, 8'hB1); set_s1(1, 3'd3, 6'd50, 6'd51, 8'hB2);
    step_cmp("R8 unknown older alone on int", 1, 8'hB1, 0, 0, 2'd1);
    set_s0(1, 3'd3, 6'd52, 1, 8'hB3); set_s1(1, 3'd7, 6'd1, 6'd2, 8'hB4);
    step_cmp("R8 unknown younger not paired", 0, 0, 1, 8'hB3, 2'd1);
    set_s0(1, 3'd0, 6'd1, 0, 8'hB5); set_s1(0, 3'd1, 6'd1, 6'd2, 8'hB6);
    step_cmp("R8 code 0 on int", 1, 8'hB5, 0, 0, 2'd1);
  endtask

  task automatic t_latency;
    set_s0(1, 3'd1, 6'd3, 1, 8'hC1); set_s1(1, 3'd3, 6'd53, 6'd54, 8'hC2);
    @(posedge clk); #1;
    set_s0(0, 3'd1, 6'd0, 0, 8'h00); set_s1(0, 3'd1, 6'd0, 6'd0, 8'h00);
    cmp("R10 pair visible after edge", 1, 8'hC1, 1, 8'hC2, 2'd2);
    @(negedge clk);
    cmp("R10 held until next edge", 1, 8'hC1, 1, 8'hC2, 2'd2);
    step_cmp("R10 cleared when idle", 0, 0, 0, 0, 2'd0);
  endtask

  initial begin
    stall = 1'b0;
    set_s0(0, 3'd1, 6'd0, 0, 8'h00);
    set_s1(0, 3'd1, 6'd0, 6'd0, 8'h00);
    fork
      begin
        t_reset();
        t_steer();
        t_pair();
        t_same();
        t_raw();
        t_older_invalid();
        t_stall();
        t_unknown();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule